// File: doc/BRIEF.md
# Operand Address Generator

This block turns a 6-bit operand specifier into a place where the operand lives. That place is either a general register or a 16-bit memory address tagged with an address space (instruction or data). The instruction sequencer pulses `start` together with the specifier, the operand size and two flags. The block then reads the register file, applies the register side effect that the addressing mode implies, and fetches any index word or pointer word it needs over a simple request/ready memory port. When it has finished it raises `done` for one cycle. Each register step is also reported as a compact recovery record, so that a later fault handler can undo the step.

Bits 5:3 of the specifier select the mode and bits 2:0 select the register. Register 6 is the stack pointer and register 7 is the program counter. The address-space encoding is 0 for instruction space and 1 for data space. A read-modify-write instruction issues a second request with `reuse` set for its write-back. That request returns the result kept from the previous request without touching any register or memory.

Top module: `oeg_operand_ea`

## Requirements
- R1: Mode 0 (register direct) finishes with `is_reg`=1 and `reg_idx` equal to the specifier register, makes no register write and no memory request; if `addr_only` is set, `err_addr` is raised with `done`.
- R2: Mode 1 returns the register value as `ea`, with no register write; `ea_space` is 0 (instruction) when the register is 7 and 1 (data) otherwise.
- R3: Mode 2 returns the old register value as `ea` (same space rule as R2) and writes back the register plus a step: 2 for registers 6 and 7 or for a word operand, 1 for a byte operand on registers 0 to 5.
- R4: Mode 4 writes back the register minus the step of R3 and returns the new value as `ea` in data space; modes 4 and 5 with register 7 raise `err_rsvd` with no register write and no memory request.
- R5: Modes 3 and 5 always step by 2. Mode 3 fetches a pointer at the old register value, from instruction space when the register is 7 and from data space otherwise. Mode 5 fetches a pointer at the decremented value from data space. The pointer becomes `ea`, in data space.
- R6: Modes 6 and 7 fetch an index word from instruction space at the program counter and write the program counter plus 2. `ea` is the register (the incremented program counter when the register is 7) plus the index, modulo 2^16, in data space. Mode 7 then fetches a pointer at that sum from data space and returns the pointer as `ea`.
- R7: Every autoincrement or autodecrement write pulses `rec_we` in the same cycle. `rec_data` bits 7:3 carry the signed step as 5-bit two's complement and bits 2:0 carry the register. The program-counter update of R6 makes no record.
- R8: A `start` with `reuse`=1 raises `done` in the next cycle with `ea`, `ea_space`, `is_reg` and the error flags of the previous request. It makes no register write and no memory request.
- R9: A word operand (`byte_op`=0) whose final `ea` is odd raises `err_addr`, and the register side effects still take place. If a pointer or index word would be fetched at an odd address, `err_addr` is raised instead, with no memory request and no register write for that step.
- R10: `mem_req` stays high with a stable `mem_addr` and `mem_space` until `mem_ready`. A request with no fetch raises `done` two cycles after `start` is taken.
- R11: `done` is a single-cycle pulse, and `ea`, `ea_space`, `is_reg` and `reg_idx` hold their values until the next request. After reset, `done`, `mem_req`, `rf_we` and `rec_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a request (taken when idle) |
| spec | input | 6 | Operand specifier: mode in 5:3, register in 2:0 |
| byte_op | input | 1 | Operand is a byte (1) or a word (0) |
| addr_only | input | 1 | Caller needs an address, not a register |
| reuse | input | 1 | Write-back half of read-modify-write: return the stored result |
| rf_rd_idx | output | 3 | Register-file read index |
| rf_rd_data | input | 16 | Register-file read data |
| rf_pc | input | 16 | Current program counter (register 7) |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 3 | Register-file write index |
| rf_wr_data | output | 16 | Register-file write data |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 16 | Memory read address |
| mem_space | output | 1 | Memory space: 0 instruction, 1 data |
| mem_rdata | input | 16 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory read complete |
| done | output | 1 | Result valid (one-cycle pulse) |
| is_reg | output | 1 | Operand is a register |
| reg_idx | output | 3 | Register of the specifier |
| ea | output | 16 | Effective address |
| ea_space | output | 1 | Space of the effective address |
| rec_we | output | 1 | Recovery record valid |
| rec_data | output | 8 | Recovery record: signed step, register |
| err_addr | output | 1 | Address error, valid with done |
| err_rsvd | output | 1 | Reserved-mode error, valid with done |

## Verification
Some properties are checked on every cycle. Write-back under `reuse` stays silent. Register 7 is never written in the predecrement modes. Every recovery record is paired with a register write to the same register. Index fetches always target instruction space. No memory request ever carries an odd address. A pending request holds steady until ready, and `done` never lasts longer than one cycle. The arithmetic results can only be shown by the directed scenarios, which compare the bench's own register and memory models against the expected values: the step sizes for each register and size, the index wrap modulo 2^16, the pointer values, the recovery record encodings, the choice of space for program-counter accesses, and the retained side effects when an odd address is reported.

// File: rtl/oeg_pkg.sv
package oeg_pkg;

   localparam int unsigned REG_IDX_W = 3;
   localparam int unsigned SPEC_W    = 6;

   localparam logic [REG_IDX_W-1:0] REG_SP = 3'd6;
   localparam logic [REG_IDX_W-1:0] REG_PC = 3'd7;

   localparam logic SPACE_I = 1'b0;
   localparam logic SPACE_D = 1'b1;

   typedef enum logic [2:0] {
      AM_REG    = 3'd0,
      AM_DEF    = 3'd1,
      AM_INC    = 3'd2,
      AM_INCDEF = 3'd3,
      AM_DEC    = 3'd4,
      AM_DECDEF = 3'd5,
      AM_IDX    = 3'd6,
      AM_IDXDEF = 3'd7
   } addr_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_CALC = 3'd1,
      ST_IDX  = 3'd2,
      ST_PTR  = 3'd3,
      ST_DONE = 3'd4
   } oeg_state_e;

endpackage

// File: rtl/oeg_step_calc.sv
module oeg_step_calc
   import oeg_pkg::*;
#(
   parameter int unsigned STEP_W = 5
) (
   input  logic [2:0]           mode_bits,
   input  logic [REG_IDX_W-1:0] regn,
   input  logic                 byte_op,
   output logic [STEP_W-1:0]    step
);

   logic two;

   // deferred modes (odd mode numbers) and SP/PC always step a full word
   assign two  = mode_bits[0] || (regn == REG_SP) || (regn == REG_PC) || !byte_op;
   assign step = two ? STEP_W'(2) : STEP_W'(1);

endmodule

// File: rtl/oeg_addr_adder.sv
module oeg_addr_adder #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y
);

   assign y = sub ? (a - b) : (a + b);

endmodule

// File: rtl/oeg_rec_fmt.sv
module oeg_rec_fmt
   import oeg_pkg::*;
#(
   parameter int unsigned STEP_W = 5,
   localparam int unsigned REC_W = STEP_W + REG_IDX_W
) (
   input  logic [STEP_W-1:0]    step,
   input  logic                 dec,
   input  logic [REG_IDX_W-1:0] regn,
   output logic [REC_W-1:0]     rec
);

   logic [STEP_W-1:0] signed_step;

   assign signed_step = dec ? (~step + STEP_W'(1)) : step;
   assign rec         = {signed_step, regn};

endmodule

// File: rtl/oeg_operand_ea.sv
module oeg_operand_ea
   import oeg_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned STEP_W    = 5,
   parameter bit          ODD_CHECK = 1'b1,
   localparam int unsigned REC_W    = STEP_W + REG_IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [SPEC_W-1:0]    spec,
   input  logic                 byte_op,
   input  logic                 addr_only,
   input  logic                 reuse,
   output logic [REG_IDX_W-1:0] rf_rd_idx,
   input  logic [DATA_W-1:0]    rf_rd_data,
   input  logic [DATA_W-1:0]    rf_pc,
   output logic                 rf_we,
   output logic [REG_IDX_W-1:0] rf_wr_idx,
   output logic [DATA_W-1:0]    rf_wr_data,
   output logic                 mem_req,
   output logic [DATA_W-1:0]    mem_addr,
   output logic                 mem_space,
   input  logic [DATA_W-1:0]    mem_rdata,
   input  logic                 mem_ready,
   output logic                 done,
   output logic                 is_reg,
   output logic [REG_IDX_W-1:0] reg_idx,
   output logic [DATA_W-1:0]    ea,
   output logic                 ea_space,
   output logic                 rec_we,
   output logic [REC_W-1:0]     rec_data,
   output logic                 err_addr,
   output logic                 err_rsvd
);

   initial begin : p_param_chk
      assert (DATA_W >= 8 && (DATA_W % 2) == 0)
         else $error("DATA_W must be even and at least 8");
      assert (STEP_W >= 3)
         else $error("STEP_W must hold a signed step of 2");
   end

   // ------------------------------------------------------------------
   // State
   // ------------------------------------------------------------------
   oeg_state_e           state_q, state_d;
   addr_mode_e           mode_q, mode_d;
   logic [2:0]           mode_bits;
   logic [REG_IDX_W-1:0] reg_q, reg_d;
   logic                 byte_q, byte_d;
   logic                 aonly_q, aonly_d;
   logic [DATA_W-1:0]    base_q, base_d;
   logic [DATA_W-1:0]    faddr_q, faddr_d;
   logic                 fspace_q, fspace_d;
   logic [DATA_W-1:0]    ea_q, ea_d;
   logic                 space_q, space_d;
   logic                 is_reg_q, is_reg_d;
   logic                 err_addr_q, err_addr_d;
   logic                 err_rsvd_q, err_rsvd_d;

   assign mode_bits = mode_q;

   // ------------------------------------------------------------------
   // Datapath helpers
   // ------------------------------------------------------------------
   logic [STEP_W-1:0] step_mag;
   logic [DATA_W-1:0] step_ext;
   logic [DATA_W-1:0] step_res;
   logic [DATA_W-1:0] pc_plus2;
   logic [DATA_W-1:0] idx_sum;
   logic              is_pc;

   assign is_pc    = (reg_q == REG_PC);
   assign step_ext = DATA_W'(step_mag);

   oeg_step_calc #(.STEP_W(STEP_W)) u_step (
      .mode_bits (mode_bits),
      .regn      (reg_q),
      .byte_op   (byte_q),
      .step      (step_mag)
   );

   oeg_addr_adder #(.W(DATA_W)) u_autostep (
      .a   (rf_rd_data),
      .b   (step_ext),
      .sub (mode_bits[2]),
      .y   (step_res)
   );

   oeg_addr_adder #(.W(DATA_W)) u_pcinc (
      .a   (rf_pc),
      .b   (DATA_W'(2)),
      .sub (1'b0),
      .y   (pc_plus2)
   );

   oeg_addr_adder #(.W(DATA_W)) u_index (
      .a   (base_q),
      .b   (mem_rdata),
      .sub (1'b0),
      .y   (idx_sum)
   );

   oeg_rec_fmt #(.STEP_W(STEP_W)) u_rec (
      .step (step_mag),
      .dec  (mode_bits[2]),
      .regn (reg_q),
      .rec  (rec_data)
   );

   // ------------------------------------------------------------------
   // Odd-address detection (optional variant)
   // ------------------------------------------------------------------
   logic odd_reg, odd_pc, odd_sum, odd_ea;

   generate
      if (ODD_CHECK) begin : g_odd
         assign odd_reg = rf_rd_data[0];
         assign odd_pc  = rf_pc[0];
         assign odd_sum = idx_sum[0];
         assign odd_ea  = ea_q[0];
      end else begin : g_no_odd
         assign odd_reg = 1'b0;
         assign odd_pc  = 1'b0;
         assign odd_sum = 1'b0;
         assign odd_ea  = 1'b0;
      end
   endgenerate

   // ------------------------------------------------------------------
   // Sequencer
   // ------------------------------------------------------------------
   always_comb begin
      state_d    = state_q;
      mode_d     = mode_q;
      reg_d      = reg_q;
      byte_d     = byte_q;
      aonly_d    = aonly_q;
      base_d     = base_q;
      faddr_d    = faddr_q;
      fspace_d   = fspace_q;
      ea_d       = ea_q;
      space_d    = space_q;
      is_reg_d   = is_reg_q;
      err_addr_d = err_addr_q;
      err_rsvd_d = err_rsvd_q;

      rf_we      = 1'b0;
      rf_wr_idx  = reg_q;
      rf_wr_data = step_res;
      rec_we     = 1'b0;
      mem_req    = 1'b0;

      case (state_q)
         ST_IDLE: begin
            if (start) begin
               if (reuse) begin
                  state_d = ST_DONE;
               end else begin
                  mode_d     = addr_mode_e'(spec[5:3]);
                  reg_d      = spec[2:0];
                  byte_d     = byte_op;
                  aonly_d    = addr_only;
                  is_reg_d   = 1'b0;
                  err_addr_d = 1'b0;
                  err_rsvd_d = 1'b0;
                  state_d    = ST_CALC;
               end
            end
         end

         ST_CALC: begin
            state_d = ST_DONE;
            case (mode_q)
               AM_REG: begin
                  is_reg_d   = 1'b1;
                  err_addr_d = aonly_q;
               end
               AM_DEF: begin
                  ea_d    = rf_rd_data;
                  space_d = is_pc ? SPACE_I : SPACE_D;
               end
               AM_INC: begin
                  ea_d    = rf_rd_data;
                  space_d = is_pc ? SPACE_I : SPACE_D;
                  rf_we   = 1'b1;
                  rec_we  = 1'b1;
               end
               AM_INCDEF: begin
                  if (odd_reg) begin
                     err_addr_d = 1'b1;
                  end else begin
                     rf_we    = 1'b1;
                     rec_we   = 1'b1;
                     faddr_d  = rf_rd_data;
                     fspace_d = is_pc ? SPACE_I : SPACE_D;
                     state_d  = ST_PTR;
                  end
               end
               AM_DEC: begin
                  if (is_pc) begin
                     err_rsvd_d = 1'b1;
                  end else begin
                     rf_we   = 1'b1;
                     rec_we  = 1'b1;
                     ea_d    = step_res;
                     space_d = SPACE_D;
                  end
               end
               AM_DECDEF: begin
                  if (is_pc) begin
                     err_rsvd_d = 1'b1;
                  end else if (odd_reg) begin
                     err_addr_d = 1'b1;
                  end else begin
                     rf_we    = 1'b1;
                     rec_we   = 1'b1;
                     faddr_d  = step_res;
                     fspace_d = SPACE_D;
                     state_d  = ST_PTR;
                  end
               end
               AM_IDX, AM_IDXDEF: begin
                  if (odd_pc) begin
                     err_addr_d = 1'b1;
                  end else begin
                     base_d   = is_pc ? pc_plus2 : rf_rd_data;
                     faddr_d  = rf_pc;
                     fspace_d = SPACE_I;
                     state_d  = ST_IDX;
                  end
               end
               default: state_d = ST_DONE;
            endcase
         end

         ST_IDX: begin
            mem_req = 1'b1;
            if (mem_ready) begin
               rf_we      = 1'b1;
               rf_wr_idx  = REG_PC;
               rf_wr_data = pc_plus2;
               if (mode_q == AM_IDXDEF) begin
                  if (odd_sum) begin
                     err_addr_d = 1'b1;
                     state_d    = ST_DONE;
                  end else begin
                     faddr_d  = idx_sum;
                     fspace_d = SPACE_D;
                     state_d  = ST_PTR;
                  end
               end else begin
                  ea_d    = idx_sum;
                  space_d = SPACE_D;
                  state_d = ST_DONE;
               end
            end
         end

         ST_PTR: begin
            mem_req = 1'b1;
            if (mem_ready) begin
               ea_d    = mem_rdata;
               space_d = SPACE_D;
               state_d = ST_DONE;
            end
         end

         ST_DONE: state_d = ST_IDLE;

         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         mode_q     <= AM_REG;
         reg_q      <= '0;
         byte_q     <= 1'b0;
         aonly_q    <= 1'b0;
         base_q     <= '0;
         faddr_q    <= '0;
         fspace_q   <= SPACE_D;
         ea_q       <= '0;
         space_q    <= SPACE_D;
         is_reg_q   <= 1'b0;
         err_addr_q <= 1'b0;
         err_rsvd_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         mode_q     <= mode_d;
         reg_q      <= reg_d;
         byte_q     <= byte_d;
         aonly_q    <= aonly_d;
         base_q     <= base_d;
         faddr_q    <= faddr_d;
         fspace_q   <= fspace_d;
         ea_q       <= ea_d;
         space_q    <= space_d;
         is_reg_q   <= is_reg_d;
         err_addr_q <= err_addr_d;
         err_rsvd_q <= err_rsvd_d;
      end
   end

   // ------------------------------------------------------------------
   // Outputs
   // ------------------------------------------------------------------
   assign rf_rd_idx = reg_q;
   assign mem_addr  = faddr_q;
   assign mem_space = fspace_q;
   assign done      = (state_q == ST_DONE);
   assign is_reg    = is_reg_q;
   assign reg_idx   = reg_q;
   assign ea        = ea_q;
   assign ea_space  = space_q;
   assign err_rsvd  = done && err_rsvd_q;
   assign err_addr  = done && (err_addr_q ||
                      (odd_ea && !is_reg_q && !byte_q && !err_rsvd_q));

endmodule

// File: rtl/oeg_operand_ea_chk.sv
module oeg_operand_ea_chk
   import oeg_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned REC_W  = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic                 reuse,
   input oeg_state_e           state_q,
   input logic [2:0]           mode_bits,
   input logic                 rf_we,
   input logic [REG_IDX_W-1:0] rf_wr_idx,
   input logic                 rec_we,
   input logic [REC_W-1:0]     rec_data,
   input logic                 mem_req,
   input logic [DATA_W-1:0]    mem_addr,
   input logic                 mem_space,
   input logic                 mem_ready,
   input logic                 done
);

   a_r8_reuse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start && reuse) |=> (done && !rf_we && !mem_req));

   a_r4_no_pc_predec: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CALC && mode_bits[2:1] == 2'b10 && rf_we) |-> (rf_wr_idx != REG_PC));

   a_r7_rec_paired: assert property (@(posedge clk) disable iff (!rst_n)
      rec_we |-> (rf_we && rf_wr_idx == rec_data[REG_IDX_W-1:0]));

   a_r6_index_ispace: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && state_q == ST_IDX) |-> (mem_space == SPACE_I));

   a_r9_even_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !mem_addr[0]);

   a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_space)));

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind oeg_operand_ea oeg_operand_ea_chk #(.DATA_W(DATA_W), .REC_W(REC_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .reuse     (reuse),
   .state_q   (state_q),
   .mode_bits (mode_bits),
   .rf_we     (rf_we),
   .rf_wr_idx (rf_wr_idx),
   .rec_we    (rec_we),
   .rec_data  (rec_data),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .mem_space (mem_space),
   .mem_ready (mem_ready),
   .done      (done)
);

// File: tb/test_oeg_operand_ea.sv
module test_oeg_operand_ea;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  spec = '0;
   logic        byte_op = 1'b0;
   logic        addr_only = 1'b0;
   logic        reuse = 1'b0;
   logic [2:0]  rf_rd_idx;
   logic [15:0] rf_rd_data;
   logic [15:0] rf_pc;
   logic        rf_we;
   logic [2:0]  rf_wr_idx;
   logic [15:0] rf_wr_data;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_space;
   logic [15:0] mem_rdata;
   logic        mem_ready;
   logic        done;
   logic        is_reg;
   logic [2:0]  reg_idx;
   logic [15:0] ea;
   logic        ea_space;
   logic        rec_we;
   logic [7:0]  rec_data;
   logic        err_addr;
   logic        err_rsvd;

   always #10 clk = ~clk;   // 50 MHz

   oeg_operand_ea i_oeg_operand_ea (
      .clk, .rst_n, .start, .spec, .byte_op, .addr_only, .reuse,
      .rf_rd_idx, .rf_rd_data, .rf_pc, .rf_we, .rf_wr_idx, .rf_wr_data,
      .mem_req, .mem_addr, .mem_space, .mem_rdata, .mem_ready,
      .done, .is_reg, .reg_idx, .ea, .ea_space, .rec_we, .rec_data,
      .err_addr, .err_rsvd
   );

   // ---------------- register file and memory models ----------------
   logic [15:0] regs [8];
   logic        ld_en = 1'b0;
   logic [2:0]  ld_idx = '0;
   logic [15:0] ld_val = '0;
   int          mem_lat = 0;
   int          lat_cnt;
   int          wr_cnt, rec_cnt, fetch_cnt, ifetch_cnt;
   logic [7:0]  last_rec;
   logic        last_fspace;

   function automatic logic [15:0] memf(input logic [15:0] a);
      return a * 16'd5 + 16'h0F0E;
   endfunction

   assign rf_rd_data = regs[rf_rd_idx];
   assign rf_pc      = regs[7];
   assign mem_rdata  = memf(mem_addr);
   assign mem_ready  = mem_req && (lat_cnt >= mem_lat);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) regs[i] <= '0;
         lat_cnt <= 0; wr_cnt <= 0; rec_cnt <= 0; fetch_cnt <= 0; ifetch_cnt <= 0;
         last_rec <= '0; last_fspace <= 1'b1;
      end else begin
         if (ld_en) regs[ld_idx] <= ld_val;
         else if (rf_we) regs[rf_wr_idx] <= rf_wr_data;
         if (rf_we) wr_cnt <= wr_cnt + 1;
         if (rec_we) begin rec_cnt <= rec_cnt + 1; last_rec <= rec_data; end
         if (mem_ready) begin
            fetch_cnt <= fetch_cnt + 1;
            last_fspace <= mem_space;
            if (mem_space == 1'b0) ifetch_cnt <= ifetch_cnt + 1;
         end
         if (mem_ready || !mem_req) lat_cnt <= 0;
         else lat_cnt <= lat_cnt + 1;
      end
   end

   // ---------------- bookkeeping ----------------
   int n_checks = 0;
   int n_err = 0;
   int cyc = 0;

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 100000) begin
         n_checks++; n_err++;
         $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
         report();
         $finish;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // results of the last request
   logic [15:0] o_ea;
   logic        o_space, o_isreg, o_eaddr, o_ersvd, o_pulse;
   logic [2:0]  o_idx;
   int          o_lat, d_wr, d_rec, d_fetch, d_ifetch;

   task automatic set_reg(input logic [2:0] idx, input logic [15:0] v);
      @(negedge clk);
      ld_en = 1'b1; ld_idx = idx; ld_val = v;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic run_op(input logic [5:0] sp, input bit bo, input bit ao, input bit ru);
      int w0, r0, f0, i0;
      @(negedge clk);
      w0 = wr_cnt; r0 = rec_cnt; f0 = fetch_cnt; i0 = ifetch_cnt;
      spec = sp; byte_op = bo; addr_only = ao; reuse = ru; start = 1'b1;
      @(negedge clk);
      start = 1'b0; reuse = 1'b0; addr_only = 1'b0;
      o_lat = 1;
      while (!done && o_lat < 200) begin
         @(negedge clk);
         o_lat++;
      end
      o_ea = ea; o_space = ea_space; o_isreg = is_reg; o_idx = reg_idx;
      o_eaddr = err_addr; o_ersvd = err_rsvd;
      d_wr = wr_cnt - w0; d_rec = rec_cnt - r0;
      d_fetch = fetch_cnt - f0; d_ifetch = ifetch_cnt - i0;
      @(negedge clk);
      o_pulse = !done;
      if (o_lat >= 200) chk("R10", "done never rose", 32'd0, 32'd1);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      chk("R11", "done after reset", done, 0);
      chk("R11", "mem_req after reset", mem_req, 0);
      chk("R11", "rf_we after reset", rf_we, 0);
      chk("R11", "rec_we after reset", rec_we, 0);
   endtask

   task automatic t_direct();
      set_reg(3, 16'h1234);
      run_op(6'o03, 1'b0, 1'b0, 1'b0);
      chk("R1", "is_reg", o_isreg, 1);
      chk("R1", "reg_idx", o_idx, 3);
      chk("R1", "no writes or fetches", d_wr + d_fetch, 0);
      chk("R1", "no error", o_eaddr, 0);
      chk("R10", "latency without fetch", o_lat, 2);
      chk("R11", "done is one cycle", o_pulse, 1);
      run_op(6'o03, 1'b0, 1'b1, 1'b0);
      chk("R1", "address request on register", o_eaddr, 1);
   endtask

   task automatic t_deferred();
      set_reg(2, 16'h2000);
      run_op(6'o12, 1'b0, 1'b0, 1'b0);
      chk("R2", "ea", o_ea, 16'h2000);
      chk("R2", "space data", o_space, 1);
      chk("R2", "no write", d_wr, 0);
      set_reg(7, 16'h0800);
      run_op(6'o17, 1'b0, 1'b0, 1'b0);
      chk("R2", "pc ea", o_ea, 16'h0800);
      chk("R2", "pc space instr", o_space, 0);
      set_reg(2, 16'h2001);
      run_op(6'o12, 1'b0, 1'b0, 1'b0);
      chk("R9", "odd word ea", o_eaddr, 1);
      run_op(6'o12, 1'b1, 1'b0, 1'b0);
      chk("R9", "odd byte ea allowed", o_eaddr, 0);
   endtask

   task automatic t_postinc();
      set_reg(1, 16'h0100);
      run_op(6'o21, 1'b1, 1'b0, 1'b0);
      chk("R3", "byte ea", o_ea, 16'h0100);
      chk("R3", "byte step 1", regs[1], 16'h0101);
      chk("R7", "record +1 r1", last_rec, 8'h09);
      chk("R7", "one record", d_rec, 1);
      set_reg(6, 16'h0400);
      run_op(6'o26, 1'b1, 1'b0, 1'b0);
      chk("R3", "sp byte step 2", regs[6], 16'h0402);
      chk("R7", "record +2 sp", last_rec, 8'h16);
      set_reg(1, 16'h0100);
      run_op(6'o21, 1'b0, 1'b0, 1'b0);
      chk("R3", "word step 2", regs[1], 16'h0102);
   endtask

   task automatic t_predec();
      set_reg(4, 16'h0300);
      run_op(6'o44, 1'b1, 1'b0, 1'b0);
      chk("R4", "byte predec value", regs[4], 16'h02FF);
      chk("R4", "ea is new value", o_ea, 16'h02FF);
      chk("R4", "space data", o_space, 1);
      chk("R7", "record -1 r4", last_rec, 8'hFC);
      set_reg(4, 16'h0301);
      run_op(6'o44, 1'b0, 1'b0, 1'b0);
      chk("R9", "odd word after predec", o_eaddr, 1);
      chk("R9", "side effect kept", regs[4], 16'h02FF);
      set_reg(7, 16'h0A00);
      run_op(6'o47, 1'b0, 1'b0, 1'b0);
      chk("R4", "pc predec reserved", o_ersvd, 1);
      chk("R4", "pc predec quiet", d_wr + d_fetch, 0);
      chk("R4", "pc unchanged", regs[7], 16'h0A00);
   endtask

   task automatic t_indirect();
      mem_lat = 2;
      set_reg(5, 16'h0500);
      run_op(6'o35, 1'b1, 1'b0, 1'b0);
      chk("R5", "postinc pointer", o_ea, memf(16'h0500));
      chk("R5", "deferred byte step 2", regs[5], 16'h0502);
      chk("R5", "pointer from data", last_fspace, 1);
      chk("R7", "record +2 r5", last_rec, 8'h15);
      set_reg(7, 16'h1000);
      run_op(6'o37, 1'b0, 1'b0, 1'b0);
      chk("R5", "pc pointer", o_ea, memf(16'h1000));
      chk("R5", "pc pointer from instr", d_ifetch, 1);
      chk("R5", "pc stepped", regs[7], 16'h1002);
      set_reg(0, 16'h0600);
      run_op(6'o50, 1'b0, 1'b0, 1'b0);
      chk("R5", "predec pointer", o_ea, memf(16'h05FE));
      chk("R5", "predec value", regs[0], 16'h05FE);
      chk("R7", "record -2 r0", last_rec, 8'hF0);
      set_reg(5, 16'h0701);
      run_op(6'o35, 1'b0, 1'b0, 1'b0);
      chk("R9", "odd pointer address", o_eaddr, 1);
      chk("R9", "no fetch no write", d_fetch + d_wr, 0);
      chk("R9", "register unchanged", regs[5], 16'h0701);
   endtask

   task automatic t_index();
      logic [15:0] exp;
      mem_lat = 3;
      set_reg(3, 16'hFFF0);
      set_reg(7, 16'h2000);
      run_op(6'o63, 1'b0, 1'b0, 1'b0);
      exp = 16'hFFF0 + memf(16'h2000);
      chk("R6", "index wraps", o_ea, exp);
      chk("R6", "pc plus 2", regs[7], 16'h2002);
      chk("R6", "index from instr", d_ifetch, 1);
      chk("R7", "no record for index", d_rec, 0);
      run_op(6'o67, 1'b0, 1'b0, 1'b0);
      exp = 16'h2004 + memf(16'h2002);
      chk("R6", "pc relative", o_ea, exp);
      set_reg(1, 16'h0010);
      set_reg(7, 16'h3000);
      run_op(6'o71, 1'b0, 1'b0, 1'b0);
      exp = memf(16'h0010 + memf(16'h3000));
      chk("R6", "index deferred", o_ea, exp);
      chk("R6", "two fetches", d_fetch, 2);
      chk("R6", "pointer from data", last_fspace, 1);
      mem_lat = 0;
   endtask

   task automatic t_reuse();
      logic [15:0] r1;
      set_reg(1, 16'h0200);
      run_op(6'o21, 1'b0, 1'b0, 1'b0);
      r1 = regs[1];
      run_op(6'o21, 1'b0, 1'b0, 1'b1);
      chk("R8", "reuse ea", o_ea, 16'h0200);
      chk("R8", "reuse space", o_space, 1);
      chk("R8", "reuse latency", o_lat, 1);
      chk("R8", "reuse no side effect", d_wr + d_fetch, 0);
      chk("R8", "register not stepped again", regs[1], r1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_direct();
      t_deferred();
      t_postinc();
      t_predec();
      t_indirect();
      t_index();
      t_reuse();
      report();
      $finish;
   end

endmodule